// File: doc/BRIEF.md
# Dual-Edge ADC Sample Capture Packer

This block sits directly behind a parallel converter bus whose samples arrive on both the rising and the falling edge of the converter's data-ready clock. Each sample carries 14 data bits and an over-range flag. Each sample is widened into a 16-bit lane that holds a constant zero bit. The sample taken on a rising edge and the one taken on the falling edge that follows are joined into one 32-bit word, which is pushed into the write side of an asynchronous FIFO. A 200 MHz data-ready clock therefore moves 400 million samples per second as 200 million words.

A control FSM raises a capture enable and supplies a requested sample count. The block counts the samples it has written. It stops when that count is met or when a forced stop arrives. It then raises a done flag, and a separate flag shows that the stop was forced, so the controller can raise an interrupt. Dropping the enable returns the block to a clean idle state, ready for the next capture.

Top module: `adc_pair_capture`

## Requirements
- R1: Each lane is 16 bits wide. Bit 15 is always 0, bits 14:1 carry the 14 data bits and bit 0 carries the over-range flag.
- R2: A written word holds the rising-edge sample in bits 31:16 and the falling-edge sample of the same clock period in bits 15:0. While a capture runs and the FIFO has room, one word is written per clock period.
- R3: Nothing is written while cap_en is low. The first rising-edge edge after cap_en is seen high only arms the block. The rising sample of the first word is taken on the second such edge, and that word is presented with fifo_wr during the clock period that follows.
- R4: A capture ends once the number of samples written reaches the requested count. At that point cap_done is raised and stays high while cap_en stays high, and no further word is written. A requested count of 0 writes no words.
- R5: An odd requested count is rounded up to the next even number. For example, a request for 7 samples yields 4 words.
- R6: When force_stop is seen on a rising edge during a capture, the capture ends at that edge. The pair already in progress is still written, and both cap_done and stop_forced go high.
- R7: While fifo_full is high, fifo_wr stays low and the pending pair is dropped. The drop sets overflow, which stays set. Dropped pairs do not count, so the capture goes on until the full requested count has been written.
- R8: A rising edge that sees cap_en low clears the sample count, the pairing phase, cap_done, stop_forced and overflow, and it discards any pending pair. The next capture starts again on a rising-edge sample, as in R3.
- R9: While rst_n is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dry_clk | input | 1 | Converter data-ready clock; samples are taken on both of its edges |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cap_en | input | 1 | Capture enable from the control FSM; low clears the block |
| force_stop | input | 1 | Ends a running capture early |
| req_count | input | CNT_W | Requested number of samples; held stable during a capture |
| smp_data | input | 14 | Converter sample data |
| smp_ovr | input | 1 | Converter over-range flag |
| fifo_full | input | 1 | Full flag from the FIFO write side |
| fifo_wr | output | 1 | FIFO write strobe, one word per clock period |
| fifo_wdata | output | 32 | Packed pair of lanes, rising sample on top |
| cap_done | output | 1 | Capture finished, by count or by forced stop |
| stop_forced | output | 1 | The finished capture was ended by force_stop |
| overflow | output | 1 | Sticky: at least one pair was dropped because the FIFO was full |

## Verification
The assertions assume that req_count does not change while cap_en is high. The bench only changes the count while cap_en is low. The assertions also assume that control and sample inputs are stable around the edge that samples them. The bench changes every input one nanosecond after a clock edge, and it compares outputs half a nanosecond before the next rising edge, when the falling-edge lane has settled. The stimulus covers a normal count, an odd count, a zero count, a full FIFO during a capture, a forced stop, and an aborted capture followed by a restart.

// File: rtl/adc_cap_pkg.sv
package adc_cap_pkg;

  localparam int DATA_W = 14;
  localparam int LANE_W = DATA_W + 2;
  localparam int WORD_W = 2 * LANE_W;

  typedef logic [LANE_W-1:0] lane_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } cap_state_t;

  // zero guard on top, data in the middle, over-range flag at the bottom
  function automatic lane_t make_lane(input logic [DATA_W-1:0] d, input logic o);
    return {1'b0, d, o};
  endfunction

endpackage

// File: rtl/cap_rst_sync.sv
module cap_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  localparam int NS = (STAGES < 2) ? 2 : STAGES;

  logic [NS-1:0] sh_q;
  logic [NS-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[NS-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= sh_d;
  end

  assign rst_n_o = sh_q[NS-1];

endmodule

// File: rtl/cap_edge_lanes.sv
module cap_edge_lanes
  import adc_cap_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rise_en,
  input  logic              fall_en,
  input  logic [DATA_W-1:0] smp_data,
  input  logic              smp_ovr,
  output lane_t             rise_lane,
  output lane_t             fall_lane
);

  lane_t lane_now;
  lane_t rise_d;
  lane_t fall_d;

  always_comb begin
    lane_now = make_lane(smp_data, smp_ovr);
    rise_d   = rise_en ? lane_now : rise_lane;
    fall_d   = fall_en ? lane_now : fall_lane;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rise_lane <= '0;
    else        rise_lane <= rise_d;
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) fall_lane <= '0;
    else        fall_lane <= fall_d;
  end

endmodule

// File: rtl/cap_ctrl.sv
module cap_ctrl
  import adc_cap_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_en,
  input  logic             force_stop,
  input  logic [CNT_W-1:0] req_count,
  input  logic             fifo_full,
  output logic             take_rise,
  output logic             pair_vld,
  output logic             fifo_wr,
  output logic             cap_done,
  output logic             stop_forced,
  output logic             overflow
);

  localparam int CW = CNT_W + 1;

  cap_state_t    st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] cnt_step;
  logic [CW-1:0] goal;
  logic          pair_q, pair_d;
  logic          forced_q, forced_d;
  logic          ovf_q, ovf_d;
  logic          wr;
  logic          reach;

  always_comb begin
    goal     = {1'b0, req_count} + CW'(req_count[0]);
    wr       = pair_q & cap_en & ~fifo_full;
    cnt_step = cnt_q + (wr ? CW'(2) : CW'(0));
    reach    = (cnt_step >= goal);

    st_d      = st_q;
    cnt_d     = cnt_q;
    pair_d    = 1'b0;
    forced_d  = forced_q;
    ovf_d     = ovf_q | (pair_q & cap_en & fifo_full);
    take_rise = 1'b0;

    if (!cap_en) begin
      st_d     = ST_IDLE;
      cnt_d    = '0;
      forced_d = 1'b0;
      ovf_d    = 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: st_d = ST_RUN;
        ST_RUN: begin
          cnt_d = cnt_step;
          if (force_stop) begin
            st_d     = ST_DONE;
            forced_d = 1'b1;
          end else if (reach) begin
            st_d = ST_DONE;
          end else begin
            take_rise = 1'b1;
            pair_d    = 1'b1;
          end
        end
        default: st_d = ST_DONE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      cnt_q    <= '0;
      pair_q   <= 1'b0;
      forced_q <= 1'b0;
      ovf_q    <= 1'b0;
    end else begin
      st_q     <= st_d;
      cnt_q    <= cnt_d;
      pair_q   <= pair_d;
      forced_q <= forced_d;
      ovf_q    <= ovf_d;
    end
  end

  assign pair_vld    = pair_q;
  assign fifo_wr     = wr;
  assign cap_done    = (st_q == ST_DONE);
  assign stop_forced = forced_q;
  assign overflow    = ovf_q;

endmodule

// File: rtl/adc_pair_capture.sv
module adc_pair_capture
  import adc_cap_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              dry_clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic              force_stop,
  input  logic [CNT_W-1:0]  req_count,
  input  logic [DATA_W-1:0] smp_data,
  input  logic              smp_ovr,
  input  logic              fifo_full,
  output logic              fifo_wr,
  output logic [WORD_W-1:0] fifo_wdata,
  output logic              cap_done,
  output logic              stop_forced,
  output logic              overflow
);

  logic  irst_n;
  logic  take_rise;
  logic  pair_vld;
  lane_t rise_lane;
  lane_t fall_lane;

  cap_rst_sync #(.STAGES(SYNC_STAGES)) i_rst (
    .clk     (dry_clk),
    .arst_n  (rst_n),
    .rst_n_o (irst_n)
  );

  cap_edge_lanes i_lanes (
    .clk       (dry_clk),
    .rst_n     (irst_n),
    .rise_en   (take_rise),
    .fall_en   (pair_vld),
    .smp_data  (smp_data),
    .smp_ovr   (smp_ovr),
    .rise_lane (rise_lane),
    .fall_lane (fall_lane)
  );

  cap_ctrl #(.CNT_W(CNT_W)) i_ctrl (
    .clk         (dry_clk),
    .rst_n       (irst_n),
    .cap_en      (cap_en),
    .force_stop  (force_stop),
    .req_count   (req_count),
    .fifo_full   (fifo_full),
    .take_rise   (take_rise),
    .pair_vld    (pair_vld),
    .fifo_wr     (fifo_wr),
    .cap_done    (cap_done),
    .stop_forced (stop_forced),
    .overflow    (overflow)
  );

  assign fifo_wdata = {rise_lane, fall_lane};

endmodule

// File: rtl/adc_pair_capture_chk.sv
module adc_pair_capture_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cap_en,
  input logic             force_stop,
  input logic [CNT_W-1:0] req_count,
  input logic             fifo_full,
  input logic             fifo_wr,
  input logic [31:0]      fifo_wdata,
  input logic             cap_done,
  input logic             stop_forced,
  input logic             overflow
);

  logic [CNT_W:0] words_q;
  logic [CNT_W:0] want;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       words_q <= '0;
    else if (!cap_en) words_q <= '0;
    else if (fifo_wr) words_q <= words_q + 1'b1;
  end

  assign want = {1'b0, req_count} + {{CNT_W{1'b0}}, req_count[0]};

  assert_lane_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_wr |-> (fifo_wdata[31] == 1'b0 && fifo_wdata[15] == 1'b0));

  assert_no_write_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_wr |-> (!fifo_full && cap_en));

  assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && cap_en) |=> overflow);

  assert_done_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_done && cap_en) |=> cap_done);

  assert_done_no_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cap_done |-> !fifo_wr);

  assert_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cap_done) && !stop_forced) |-> ((words_q << 1) == want));

  assert_forced_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stop_forced) |-> $past(force_stop));

  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en |=> (!cap_done && !stop_forced && !overflow && !fifo_wr));

endmodule

bind adc_pair_capture adc_pair_capture_chk #(.CNT_W(CNT_W)) i_chk (
  .clk         (dry_clk),
  .rst_n       (rst_n),
  .cap_en      (cap_en),
  .force_stop  (force_stop),
  .req_count   (req_count),
  .fifo_full   (fifo_full),
  .fifo_wr     (fifo_wr),
  .fifo_wdata  (fifo_wdata),
  .cap_done    (cap_done),
  .stop_forced (stop_forced),
  .overflow    (overflow)
);

// File: tb/test_adc_pair_capture.sv
`timescale 1ns/1ps
module test_adc_pair_capture;

  logic        dry_clk = 1'b0;
  logic        rst_n;
  logic        cap_en;
  logic        force_stop;
  logic [15:0] req_count;
  logic [13:0] smp_data;
  logic        smp_ovr;
  logic        fifo_full;
  logic        fifo_wr;
  logic [31:0] fifo_wdata;
  logic        cap_done;
  logic        stop_forced;
  logic        overflow;

  int checks = 0;
  int errors = 0;
  int act_words = 0;
  int sidx = 0;
  bit live = 0;
  bit ended = 0;

  // reference model state
  int m_phase = 0;  // 0 idle, 1 running, 2 finished
  int m_cnt = 0;
  bit m_half = 0;
  bit m_forced = 0;
  bit m_ovf = 0;
  int m_rise = 0;
  int m_fall = 0;

  always #2 dry_clk = ~dry_clk;

  adc_pair_capture i_adc_pair_capture (
    .dry_clk(dry_clk), .rst_n(rst_n), .cap_en(cap_en), .force_stop(force_stop),
    .req_count(req_count), .smp_data(smp_data), .smp_ovr(smp_ovr),
    .fifo_full(fifo_full), .fifo_wr(fifo_wr), .fifo_wdata(fifo_wdata),
    .cap_done(cap_done), .stop_forced(stop_forced), .overflow(overflow)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge dry_clk);
    #1;
  endtask

  function automatic int lane_of(input int d, input bit o);
    return d * 2 + o;
  endfunction

  // sample generator: new value after every edge
  initial begin
    smp_data = '0;
    smp_ovr  = 1'b0;
    forever begin
      @(posedge dry_clk); #1;
      sidx++; smp_data = 14'((sidx * 911 + 3) % 16384); smp_ovr = (sidx % 5 == 0);
      @(negedge dry_clk); #1;
      sidx++; smp_data = 14'((sidx * 911 + 3) % 16384); smp_ovr = (sidx % 5 == 0);
    end
  end

  always @(posedge dry_clk) begin
    bit w;
    int goal;
    if (!rst_n) begin
      m_phase = 0; m_cnt = 0; m_half = 0; m_forced = 0; m_ovf = 0;
    end else begin
      w = m_half && cap_en && !fifo_full;
      if (m_half && cap_en && fifo_full) m_ovf = 1;
      if (!cap_en) begin
        m_phase = 0; m_cnt = 0; m_half = 0; m_forced = 0; m_ovf = 0;
      end else if (m_phase == 0) begin
        m_phase = 1; m_half = 0;
      end else if (m_phase == 1) begin
        if (w) m_cnt += 2;
        goal = (int'(req_count) + 1) / 2 * 2;
        if (force_stop) begin
          m_phase = 2; m_forced = 1; m_half = 0;
        end else if (m_cnt >= goal) begin
          m_phase = 2; m_half = 0;
        end else begin
          m_half = 1; m_rise = lane_of(int'(smp_data), smp_ovr);
        end
      end else begin
        m_half = 0;
      end
    end
  end

  always @(negedge dry_clk) begin
    if (rst_n && m_half) m_fall = lane_of(int'(smp_data), smp_ovr);
  end

  // per-cycle comparison half a nanosecond before each rising edge
  always @(negedge dry_clk) begin
    bit ew;
    #1.5;
    if (live) begin
      ew = m_half && cap_en && !fifo_full;
      check("R2 R3 R7 R8 fifo_wr", int'(fifo_wr), int'(ew));
      if (ew) check("R1 R2 packed word", int'(fifo_wdata), m_rise * 65536 + m_fall);
      check("R4 cap_done", int'(cap_done), int'(m_phase == 2));
      check("R6 stop_forced", int'(stop_forced), int'(m_forced));
      check("R7 overflow", int'(overflow), int'(m_ovf));
    end
    if (fifo_wr) act_words++;
  end

  task automatic wait_done();
    while (!cap_done) tick(1);
  endtask

  task automatic idle(input int n);
    cap_en = 1'b0; force_stop = 1'b0; fifo_full = 1'b0;
    tick(n);
  endtask

  task automatic start(input int req);
    req_count = 16'(req);
    act_words = 0;
    cap_en = 1'b1;
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge dry_clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; cap_en = 1'b0; force_stop = 1'b0; fifo_full = 1'b0; req_count = '0;
    tick(3);
    #1.5;
    // R9: reset state
    check("R9 fifo_wr in reset", int'(fifo_wr), 0);
    check("R9 fifo_wdata in reset", int'(fifo_wdata), 0);
    check("R9 cap_done in reset", int'(cap_done), 0);
    check("R9 flags in reset", int'({stop_forced, overflow}), 0);
    #0.5;
    rst_n = 1'b1;
    tick(4);
    live = 1;

    // R4: plain count of 10 samples
    start(10);
    wait_done();
    tick(2);
    check("R4 words for 10 samples", act_words, 5);
    check("R4 done held", int'(cap_done), 1);
    idle(2);

    // R5: odd count rounded up
    start(7);
    wait_done();
    tick(2);
    check("R5 words for 7 samples", act_words, 4);
    idle(2);

    // R4: zero count
    start(0);
    tick(4);
    check("R4 words for zero count", act_words, 0);
    check("R4 done for zero count", int'(cap_done), 1);
    idle(2);

    // R7: FIFO full for three cycles
    start(20);
    tick(4);
    fifo_full = 1'b1;
    tick(3);
    fifo_full = 1'b0;
    wait_done();
    tick(1);
    check("R7 words despite drops", act_words, 10);
    check("R7 overflow sticky", int'(overflow), 1);
    idle(1);
    // R8: clear on enable low
    check("R8 overflow cleared", int'(overflow), 0);
    check("R8 done cleared", int'(cap_done), 0);
    idle(1);

    // R6: forced stop
    start(100);
    tick(6);
    force_stop = 1'b1;
    tick(1);
    force_stop = 1'b0;
    tick(1);
    check("R6 words before forced stop", act_words, 5);
    check("R6 stop_forced", int'(stop_forced), 1);
    check("R6 done after forced stop", int'(cap_done), 1);
    idle(1);
    check("R8 stop_forced cleared", int'(stop_forced), 0);
    idle(1);

    // R8 and R3: abort mid capture, then restart
    start(100);
    tick(5);
    cap_en = 1'b0;
    tick(1);
    start(6);
    tick(1);
    check("R3 no word on arming edge", act_words, 0);
    wait_done();
    tick(2);
    check("R8 words after restart", act_words, 3);
    idle(3);

    live = 0;
    finish_run();
  end

endmodule